// File: doc/BRIEF.md
# Four-Bit Cascadable ALU Slice

This block is one 4-bit slice of a microprogrammed datapath. It holds a sixteen-word register file with two read ports, a 4-bit Q register and an ALU with eight functions. A 9-bit microinstruction selects three things: the pair of ALU operands, the ALU function, and where the result goes. The result can go to the Q register, to a register-file word, or to both with a one-bit shift. The 4-bit Y output shows either the ALU result or the word read on the A port.

Wider words are built by chaining slices. The carry runs through `cIn`/`cOut`, or through the active-low group generate and propagate outputs into an external lookahead unit. Shifted bits pass between neighbouring slices on four shift pins. Each shift pin is modelled as an input, an output and an output enable, and its direction follows the shift direction. The top slice's sign and overflow outputs give the word's two's complement status. The zero outputs of all slices are combined to flag a zero word.

Top module: `alu_slice`

## Requirements
- R1: The register file has 16 words of 4 bits. `aAddr` selects the word read on the A port. `bAddr` selects the word read on the B port and also the word that is written on the rising clock edge. When an instruction writes the word it reads, it uses the word's value from before that edge.
- R2: Bits 2:0 of `instr` select the operands R and S: 0 gives A,Q; 1 gives A,B; 2 gives 0,Q; 3 gives 0,B; 4 gives 0,A; 5 gives D,A; 6 gives D,Q; 7 gives D,0. Here D is `dIn`.
- R3: Bits 5:3 select the function F. The arithmetic codes are 0 for R+S+cIn, 1 for S+~R+cIn and 2 for R+~S+cIn. The logic codes are 3 for R|S, 4 for R&S, 5 for ~R&S, 6 for R^S and 7 for ~(R^S).
- R4: Bits 8:6 select the destination, and `yOut` is the A word for code 2 and F for every other code. Code 0 loads F into Q. Code 1 writes nothing. Codes 2 and 3 write F to word `bAddr`. Code 4 writes F shifted down into `bAddr` and also shifts Q down. Code 5 writes F shifted down into `bAddr`. Code 6 writes F shifted up into `bAddr` and also shifts Q up. Code 7 writes F shifted up into `bAddr`.
- R5: `yEn` is the inverse of `oeN`.
- R6: `sign` equals F bit 3, and `zero` is 1 exactly when F is 0.
- R7: For arithmetic codes, `cOut` is the carry out of bit 3 and `ovf` is the XOR of the carries into and out of bit 3. For logic codes, both are 0.
- R8: For arithmetic codes, `propN` is low when every bit position propagates, meaning the bit is 1 in either operand after any inversion. `genN` is low when the two operands after inversion carry out with a carry-in of 0. For logic codes, both are high.
- R9: Destinations 6 and 7 drive `ram3Out` with F bit 3 and `q3Out` with Q bit 3, and enable both. The up shift takes its LSBs from `ram0In` and `q0In`.
- R10: Destinations 4 and 5 drive `ram0Out` with F bit 0 and `q0Out` with Q bit 0, and enable both. The down shift takes its MSBs from `ram3In` and `q3In`. For any other destination, all four shift enables are 0.
- R11: Reset (`rstN` low) clears Q and every register-file word.
- R12: Q changes only for destinations 0, 4 and 6. Destinations 5 and 7 shift the register-file word but leave Q unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 9 | Microinstruction: destination, function, source |
| aAddr | input | 4 | A-port read address |
| bAddr | input | 4 | B-port read and write address |
| dIn | input | 4 | Direct data operand |
| cIn | input | 1 | ALU carry-in |
| oeN | input | 1 | Active-low Y output enable |
| yOut | output | 4 | ALU result or A word |
| yEn | output | 1 | Y driver enable |
| cOut | output | 1 | ALU carry-out |
| genN | output | 1 | Active-low group generate |
| propN | output | 1 | Active-low group propagate |
| ovf | output | 1 | Two's complement overflow |
| zero | output | 1 | ALU result is zero |
| sign | output | 1 | ALU result MSB |
| ram0In | input | 1 | Up-shift LSB for register-file write |
| ram0Out | output | 1 | Down-shift LSB out (F bit 0) |
| ram0En | output | 1 | Enable for ram0Out |
| ram3In | input | 1 | Down-shift MSB for register-file write |
| ram3Out | output | 1 | Up-shift MSB out (F bit 3) |
| ram3En | output | 1 | Enable for ram3Out |
| q0In | input | 1 | Up-shift LSB for Q |
| q0Out | output | 1 | Down-shift LSB out (Q bit 0) |
| q0En | output | 1 | Enable for q0Out |
| q3In | input | 1 | Down-shift MSB for Q |
| q3Out | output | 1 | Up-shift MSB out (Q bit 3) |
| q3En | output | 1 | Enable for q3Out |

## Verification
A single cycle often reads a register-file word through the operands and writes the same word back. The same holds for Q: it can be an operand in the same cycle that it is shifted. The bench provokes both cases with directed runs, where `aAddr` equals `bAddr` and source 1 is combined with destination 3, or Q is an operand under destinations 4 and 6. Every one of the 512 instruction codes is also applied with random addresses and operands. A behavioural model in the bench predicts each cycle's outputs from the state before the clock edge. The written value only shows up when a later instruction reads it back, so an implementation that used the new value, or that wrote the wrong word, fails those later comparisons.

// File: rtl/slice_pkg.sv
package slice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
  } srcCode_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUBR, FN_SUBS, FN_OR, FN_AND, FN_NOTRS, FN_XOR, FN_XNOR
  } fnCode_e;

  typedef enum logic [2:0] {
    DST_QREG, DST_NOP, DST_RAMA, DST_RAMF, DST_RAMQD, DST_RAMD, DST_RAMQU, DST_RAMU
  } dstCode_e;

  typedef enum logic [1:0] {R_ZERO, R_AWORD, R_DIN} rSel_e;
  typedef enum logic [1:0] {S_ZERO, S_AWORD, S_BWORD, S_QREG} sSel_e;
  typedef enum logic [1:0] {LG_OR, LG_AND, LG_XOR, LG_XNOR} logicOp_e;
  typedef enum logic [1:0] {SH_NONE, SH_DOWN, SH_UP} shiftDir_e;

  typedef struct packed {
    rSel_e     rSel;
    sSel_e     sSel;
    logic      invR;
    logic      invS;
    logic      isArith;
    logicOp_e  logicOp;
    logic      qLoad;
    logic      qShift;
    logic      ramWrite;
    shiftDir_e shiftDir;
    logic      yFromA;
  } ctrl_t;

endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic [8:0] instr,
  output ctrl_t      ctl
);

  srcCode_e srcCode;
  fnCode_e  fnCode;
  dstCode_e dstCode;

  assign srcCode = srcCode_e'(instr[2:0]);
  assign fnCode  = fnCode_e'(instr[5:3]);
  assign dstCode = dstCode_e'(instr[8:6]);

  always_comb begin
    ctl = '0;
    // operand sources
    case (srcCode)
      SRC_AQ:  begin ctl.rSel = R_AWORD; ctl.sSel = S_QREG;  end
      SRC_AB:  begin ctl.rSel = R_AWORD; ctl.sSel = S_BWORD; end
      SRC_ZQ:  begin ctl.rSel = R_ZERO;  ctl.sSel = S_QREG;  end
      SRC_ZB:  begin ctl.rSel = R_ZERO;  ctl.sSel = S_BWORD; end
      SRC_ZA:  begin ctl.rSel = R_ZERO;  ctl.sSel = S_AWORD; end
      SRC_DA:  begin ctl.rSel = R_DIN;   ctl.sSel = S_AWORD; end
      SRC_DQ:  begin ctl.rSel = R_DIN;   ctl.sSel = S_QREG;  end
      default: begin ctl.rSel = R_DIN;   ctl.sSel = S_ZERO;  end
    endcase
    // function
    case (fnCode)
      FN_ADD:   ctl.isArith = 1'b1;
      FN_SUBR:  begin ctl.isArith = 1'b1; ctl.invR = 1'b1; end
      FN_SUBS:  begin ctl.isArith = 1'b1; ctl.invS = 1'b1; end
      FN_OR:    ctl.logicOp = LG_OR;
      FN_AND:   ctl.logicOp = LG_AND;
      FN_NOTRS: begin ctl.logicOp = LG_AND; ctl.invR = 1'b1; end
      FN_XOR:   ctl.logicOp = LG_XOR;
      default:  ctl.logicOp = LG_XNOR;
    endcase
    // destination
    case (dstCode)
      DST_QREG:  ctl.qLoad = 1'b1;
      DST_NOP:   ;
      DST_RAMA:  begin ctl.ramWrite = 1'b1; ctl.yFromA = 1'b1; end
      DST_RAMF:  ctl.ramWrite = 1'b1;
      DST_RAMQD: begin ctl.ramWrite = 1'b1; ctl.qShift = 1'b1; ctl.shiftDir = SH_DOWN; end
      DST_RAMD:  begin ctl.ramWrite = 1'b1; ctl.shiftDir = SH_DOWN; end
      DST_RAMQU: begin ctl.ramWrite = 1'b1; ctl.qShift = 1'b1; ctl.shiftDir = SH_UP; end
      default:   begin ctl.ramWrite = 1'b1; ctl.shiftDir = SH_UP; end
    endcase
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] rIn,
  input  logic [WIDTH-1:0] sIn,
  input  logic             cIn,
  input  logic             invR,
  input  logic             invS,
  input  logic             isArith,
  input  logicOp_e         logicOp,
  output logic [WIDTH-1:0] aluF,
  output logic             cOut,
  output logic             ovf,
  output logic             genN,
  output logic             propN
);

  logic [WIDTH-1:0] rEff, sEff, bitGen, bitProp, sumBits, logicF;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] groupGen;

  assign rEff = invR ? ~rIn : rIn;
  assign sEff = invS ? ~sIn : sIn;
  assign carry[0] = cIn;
  assign groupGen[0] = bitGen[0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitGen[i]  = rEff[i] & sEff[i];
    assign bitProp[i] = rEff[i] | sEff[i];
    assign sumBits[i] = rEff[i] ^ sEff[i] ^ carry[i];
    assign carry[i+1] = bitGen[i] | (bitProp[i] & carry[i]);
    if (i > 0) begin : g_grp
      assign groupGen[i] = bitGen[i] | (bitProp[i] & groupGen[i-1]);
    end
  end

  always_comb begin
    case (logicOp)
      LG_OR:   logicF = rEff | sEff;
      LG_AND:  logicF = rEff & sEff;
      LG_XOR:  logicF = rEff ^ sEff;
      default: logicF = ~(rEff ^ sEff);
    endcase
  end

  assign aluF  = isArith ? sumBits : logicF;
  assign cOut  = isArith & carry[WIDTH];
  assign ovf   = isArith & (carry[WIDTH] ^ carry[WIDTH-1]);
  assign genN  = ~(isArith & groupGen[WIDTH-1]);
  assign propN = ~(isArith & (&bitProp));

endmodule

// File: rtl/slice_dp.sv
module slice_dp
  import slice_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [AW-1:0]    aAddr,
  input  logic [AW-1:0]    bAddr,
  input  logic [WIDTH-1:0] dIn,
  input  logic             cIn,
  output logic [WIDTH-1:0] yOut,
  output logic             cOut,
  output logic             genN,
  output logic             propN,
  output logic             ovf,
  output logic             zero,
  output logic             sign,
  input  logic             ram0In,
  output logic             ram0Out,
  output logic             ram0En,
  input  logic             ram3In,
  output logic             ram3Out,
  output logic             ram3En,
  input  logic             q0In,
  output logic             q0Out,
  output logic             q0En,
  input  logic             q3In,
  output logic             q3Out,
  output logic             q3En
);

  logic [WIDTH-1:0] regFile [DEPTH];
  logic [WIDTH-1:0] qReg, qNext, aData, bData, rOp, sOp, aluF, ramNew;

  assign aData = regFile[aAddr];
  assign bData = regFile[bAddr];

  always_comb begin
    case (ctl.rSel)
      R_AWORD: rOp = aData;
      R_DIN:   rOp = dIn;
      default: rOp = '0;
    endcase
    case (ctl.sSel)
      S_AWORD: sOp = aData;
      S_BWORD: sOp = bData;
      S_QREG:  sOp = qReg;
      default: sOp = '0;
    endcase
  end

  slice_alu #(.WIDTH(WIDTH)) aluInst (
    .rIn(rOp), .sIn(sOp), .cIn(cIn),
    .invR(ctl.invR), .invS(ctl.invS), .isArith(ctl.isArith), .logicOp(ctl.logicOp),
    .aluF(aluF), .cOut(cOut), .ovf(ovf), .genN(genN), .propN(propN)
  );

  // write-path shifters
  always_comb begin
    case (ctl.shiftDir)
      SH_DOWN: ramNew = {ram3In, aluF[WIDTH-1:1]};
      SH_UP:   ramNew = {aluF[WIDTH-2:0], ram0In};
      default: ramNew = aluF;
    endcase
    if (ctl.qLoad)
      qNext = aluF;
    else if (ctl.qShift && ctl.shiftDir == SH_DOWN)
      qNext = {q3In, qReg[WIDTH-1:1]};
    else if (ctl.qShift)
      qNext = {qReg[WIDTH-2:0], q0In};
    else
      qNext = qReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qReg <= '0;
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else begin
      qReg <= qNext;
      if (ctl.ramWrite) regFile[bAddr] <= ramNew;
    end
  end

  assign yOut    = ctl.yFromA ? aData : aluF;
  assign zero    = (aluF == '0);
  assign sign    = aluF[WIDTH-1];
  assign ram3Out = aluF[WIDTH-1];
  assign q3Out   = qReg[WIDTH-1];
  assign ram3En  = (ctl.shiftDir == SH_UP);
  assign q3En    = (ctl.shiftDir == SH_UP);
  assign ram0Out = aluF[0];
  assign q0Out   = qReg[0];
  assign ram0En  = (ctl.shiftDir == SH_DOWN);
  assign q0En    = (ctl.shiftDir == SH_DOWN);

  // R12
  qhold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.qLoad && !ctl.qShift) |=> $stable(qReg));

  // R4
  ramwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ramWrite && ctl.shiftDir == SH_NONE) |=> (regFile[$past(bAddr)] == $past(aluF)));

  // R9
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ram3En && ram0En) && (q3En == ram3En) && (q0En == ram0En));

  // R10
  down_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ram0En && !ctl.qShift) |=> $stable(qReg));

  // R6
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    zero |-> !sign && (yOut == '0 || ctl.yFromA));

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import slice_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [8:0]       instr,
  input  logic [AW-1:0]    aAddr,
  input  logic [AW-1:0]    bAddr,
  input  logic [WIDTH-1:0] dIn,
  input  logic             cIn,
  input  logic             oeN,
  output logic [WIDTH-1:0] yOut,
  output logic             yEn,
  output logic             cOut,
  output logic             genN,
  output logic             propN,
  output logic             ovf,
  output logic             zero,
  output logic             sign,
  input  logic             ram0In,
  output logic             ram0Out,
  output logic             ram0En,
  input  logic             ram3In,
  output logic             ram3Out,
  output logic             ram3En,
  input  logic             q0In,
  output logic             q0Out,
  output logic             q0En,
  input  logic             q3In,
  output logic             q3Out,
  output logic             q3En
);

  ctrl_t ctl;

  slice_ctrl ctrlInst (.instr(instr), .ctl(ctl));

  slice_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .aAddr(aAddr), .bAddr(bAddr),
    .dIn(dIn), .cIn(cIn), .yOut(yOut), .cOut(cOut), .genN(genN), .propN(propN),
    .ovf(ovf), .zero(zero), .sign(sign),
    .ram0In(ram0In), .ram0Out(ram0Out), .ram0En(ram0En),
    .ram3In(ram3In), .ram3Out(ram3Out), .ram3En(ram3En),
    .q0In(q0In), .q0Out(q0Out), .q0En(q0En),
    .q3In(q3In), .q3Out(q3Out), .q3En(q3En)
  );

  assign yEn = ~oeN;

endmodule

// File: tb/alu_slice_test.sv
module alu_slice_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0] instr = '0;
  logic [3:0] aAddr = '0, bAddr = '0, dIn = '0;
  logic cIn = 1'b0, oeN = 1'b0;
  logic ram0In = 1'b0, ram3In = 1'b0, q0In = 1'b0, q3In = 1'b0;
  logic [3:0] yOut;
  logic yEn, cOut, genN, propN, ovf, zero, sign;
  logic ram0Out, ram0En, ram3Out, ram3En, q0Out, q0En, q3Out, q3En;

  alu_slice uut (
    .clk(clk), .rstN(rstN), .instr(instr), .aAddr(aAddr), .bAddr(bAddr),
    .dIn(dIn), .cIn(cIn), .oeN(oeN), .yOut(yOut), .yEn(yEn), .cOut(cOut),
    .genN(genN), .propN(propN), .ovf(ovf), .zero(zero), .sign(sign),
    .ram0In(ram0In), .ram0Out(ram0Out), .ram0En(ram0En),
    .ram3In(ram3In), .ram3Out(ram3Out), .ram3En(ram3En),
    .q0In(q0In), .q0Out(q0Out), .q0En(q0En),
    .q3In(q3In), .q3Out(q3Out), .q3En(q3En)
  );

  always #2ns clk = ~clk;

  typedef struct {
    int    code;
    string yReq;
    logic [3:0] y;
    logic yEn, cOut, ovf, genN, propN, zero, sign;
    logic r0En, r0Out, r3En, r3Out, q0En, q0Out, q3En, q3Out;
  } exp_t;

  exp_t expQ[$];
  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  logic [3:0] mRegs [16];
  logic [3:0] mQ;

  task automatic check(string req, string what, int code, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s instr=%0d actual=%0d expected=%0d", req, what, code, act, exp);
    end
  endtask

  // driver: applies one instruction, pushes expected item, advances model
  task automatic drive(input logic [8:0] code, input logic [3:0] aa, input logic [3:0] ba,
                       input logic [3:0] dd, input logic ci, input logic oe,
                       input logic [3:0] pins, input string yReq);
    int r, s, rr, ss, sum, f, src, fn, dst, c3;
    exp_t e;
    @(negedge clk);
    instr = code; aAddr = aa; bAddr = ba; dIn = dd; cIn = ci; oeN = oe;
    {ram0In, ram3In, q0In, q3In} = pins;
    src = int'(code[2:0]); fn = int'(code[5:3]); dst = int'(code[8:6]);
    case (src)
      0: begin r = mRegs[aa]; s = mQ; end
      1: begin r = mRegs[aa]; s = mRegs[ba]; end
      2: begin r = 0; s = mQ; end
      3: begin r = 0; s = mRegs[ba]; end
      4: begin r = 0; s = mRegs[aa]; end
      5: begin r = dd; s = mRegs[aa]; end
      6: begin r = dd; s = mQ; end
      default: begin r = dd; s = 0; end
    endcase
    e.code = code; e.yReq = yReq;
    e.cOut = 0; e.ovf = 0; e.genN = 1; e.propN = 1;
    if (fn <= 2) begin
      rr = (fn == 1) ? (~r & 15) : r;
      ss = (fn == 2) ? (~s & 15) : s;
      sum = rr + ss + ci;
      f = sum & 15;
      c3 = ((rr & 7) + (ss & 7) + ci) >> 3;
      e.cOut = sum[4];
      e.ovf = (c3 != 0) ^ sum[4];
      e.propN = !((rr | ss) == 15);
      e.genN = !(((rr + ss) >> 4) != 0);
    end else begin
      case (fn)
        3: f = r | s;
        4: f = r & s;
        5: f = ~r & s & 15;
        6: f = r ^ s;
        default: f = ~(r ^ s) & 15;
      endcase
    end
    e.y = (dst == 2) ? mRegs[aa] : f[3:0];
    e.yEn = !oe; e.zero = (f == 0); e.sign = f[3];
    e.r3En = (dst >= 6); e.q3En = (dst >= 6); e.r3Out = f[3]; e.q3Out = mQ[3];
    e.r0En = (dst == 4 || dst == 5); e.q0En = e.r0En; e.r0Out = f[0]; e.q0Out = mQ[0];
    expQ.push_back(e);
    // state update (takes effect at the next rising edge)
    case (dst)
      0: mQ = f[3:0];
      2, 3: mRegs[ba] = f[3:0];
      4: begin mRegs[ba] = {pins[2], f[3:1]}; mQ = {pins[0], mQ[3:1]}; end
      5: mRegs[ba] = {pins[2], f[3:1]};
      6: begin mRegs[ba] = {f[2:0], pins[3]}; mQ = {mQ[2:0], pins[1]}; end
      7: mRegs[ba] = {f[2:0], pins[3]};
      default: ;
    endcase
  endtask

  // monitor: compares each pushed item shortly after it is applied
  initial begin
    forever begin
      @(negedge clk);
      #1ns;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.yReq, "yOut", e.code, yOut, e.y);
        check("R5", "yEn", e.code, yEn, e.yEn);
        check("R6", "zero", e.code, zero, e.zero);
        check("R6", "sign", e.code, sign, e.sign);
        check("R7", "cOut", e.code, cOut, e.cOut);
        check("R7", "ovf", e.code, ovf, e.ovf);
        check("R8", "genN", e.code, genN, e.genN);
        check("R8", "propN", e.code, propN, e.propN);
        check("R9", "ram3En", e.code, ram3En, e.r3En);
        check("R9", "q3En", e.code, q3En, e.q3En);
        if (e.r3En) begin
          check("R9", "ram3Out", e.code, ram3Out, e.r3Out);
          check("R9", "q3Out", e.code, q3Out, e.q3Out);
        end
        check("R10", "ram0En", e.code, ram0En, e.r0En);
        check("R10", "q0En", e.code, q0En, e.q0En);
        if (e.r0En) begin
          check("R10", "ram0Out", e.code, ram0Out, e.r0Out);
          check("R10", "q0Out", e.code, q0Out, e.q0Out);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  localparam logic [8:0] RD_Q  = {3'd1, 3'd3, 3'd2}; // NOP, OR, 0/Q -> Y=Q
  localparam logic [8:0] RD_A  = {3'd1, 3'd3, 3'd4}; // NOP, OR, 0/A -> Y=A word

  initial begin
    mQ = '0;
    for (int i = 0; i < 16; i++) mRegs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state visible through normal reads
    drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R11");
    for (int i = 0; i < 16; i++) drive(RD_A, 4'(i), 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R11");
    // load registers with D (DZ, OR, RAMF) and Q with a pattern
    for (int i = 0; i < 16; i++)
      drive({3'd3, 3'd3, 3'd7}, 4'd0, 4'(i), 4'(i * 7 + 3), 1'b0, 1'b0, 4'h0, "R2");
    drive({3'd0, 3'd3, 3'd7}, 4'd0, 4'd0, 4'hA, 1'b0, 1'b1, 4'h0, "R5");
    // R1: read-modify-write of the same word, then read it back
    for (int i = 0; i < 4; i++) begin
      drive({3'd3, 3'd0, 3'd1}, 4'(i), 4'(i), 4'd0, 1'b1, 1'b0, 4'h0, "R1");
      drive(RD_A, 4'(i), 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R1");
    end
    // R12: shifts without Q leave Q alone; with Q they shift it
    drive({3'd5, 3'd3, 3'd7}, 4'd0, 4'd5, 4'h9, 1'b0, 1'b0, 4'hF, "R10");
    drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R12");
    drive({3'd7, 3'd3, 3'd7}, 4'd0, 4'd6, 4'h9, 1'b0, 1'b0, 4'hF, "R9");
    drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R12");
    drive({3'd4, 3'd0, 3'd0}, 4'd2, 4'd7, 4'd0, 1'b1, 1'b0, 4'h5, "R10");
    drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R12");
    drive(RD_A, 4'd7, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R10");
    drive({3'd6, 3'd1, 3'd0}, 4'd3, 4'd8, 4'd0, 1'b0, 1'b0, 4'hA, "R9");
    drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R12");
    drive(RD_A, 4'd8, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R9");
    // overflow corner: 7 + 1
    drive({3'd1, 3'd0, 3'd7}, 4'd0, 4'd0, 4'd7, 1'b1, 1'b0, 4'h0, "R3");
    // every instruction code with random operands
    for (int c = 0; c < 512; c++)
      drive(9'(c), 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
            1'($urandom), 4'($urandom), "R4");
    // random mix, each followed occasionally by readbacks
    for (int k = 0; k < 600; k++) begin
      drive(9'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
            1'($urandom), 4'($urandom), "R3");
      if (k % 8 == 0) begin
        drive(RD_Q, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R12");
        drive(RD_A, 4'($urandom), 4'd0, 4'd0, 1'b0, 1'b0, 4'h0, "R1");
      end
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule